// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is an 8-bit binary down-counter for a real-time clock. It advances on one of four tick rates, chosen by a two-bit field. Two of the rates are derived inside the block from two single-cycle strobes that arrive from the timekeeping core: a 4096 Hz base strobe and a once-per-second strobe. A divide-by-64 stage gives the 64 Hz rate, and a divide-by-60 stage gives a once-per-minute rate.

Software loads a start count through a simple write port. The counter steps down once for each tick of the selected rate. On the tick that would bring it to zero, it raises a sticky countdown flag and starts again from the last value that was written. A written value of zero stands for 256 ticks, so at the per-minute rate one interval can last up to 256 minutes.

The block also drives the shared interrupt line of the clock. A two-bit output select chooses what appears on that line: nothing, the alarm request, the frequency request, or this timer's flag.

Top module: `cd_timer`

## Requirements
- R1: The rate field `ctl_src` picks the tick that steps the counter: 00 = every `base_tick` strobe, 01 = every 64th `base_tick` strobe, 10 = every `sec_tick` strobe, 11 = every 60th `sec_tick` strobe. Strobes of a rate that is not selected have no effect on the count.
- R2: A pulse on `cnt_wr` stores `cnt_wdata` as the new reload value and loads it into the counter, visible on `cd_count` in the following cycle. A write takes priority over a tick that arrives in the same cycle.
- R3: While running, each selected tick lowers `cd_count` by one. A tick that arrives when `cd_count` is 1 sets `cd_flag` at that same clock edge.
- R4: `cd_flag` stays at 1 until a `flag_clr` pulse. If an expiring tick and `flag_clr` arrive in the same cycle, the flag is set.
- R5: A count of 0 counts 256 ticks, passing through 255 down to 1. At the per-minute rate this gives a 256-minute interval.
- R6: While the run bit is 0, `cd_count` holds, `cd_flag` never rises, and both derived dividers are held at their start phase.
- R7: `irq_out` follows `out_sel`: 00 gives 0, 01 gives `alarm_irq`, 10 gives `freq_irq`, 11 gives `cd_flag`. This path is combinational.
- R8: On expiry the counter reloads the last written value and keeps counting, so the flag can be raised again after it has been cleared.
- R9: A count write restarts the phase of the divide-by-64 and divide-by-60 stages. After the write, the first derived tick comes on the 64th base strobe or on the 60th second strobe.
- R10: After reset `cd_count` is 0, `cd_flag` is 0, the run bit is 0, and the rate field is 00.
- R11: A pulse on `ctl_wr` stores `ctl_run` and `ctl_src`, and they take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle 4096 Hz strobe |
| sec_tick | input | 1 | One-cycle 1 Hz strobe |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Start count (0 means 256) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit written by `ctl_wr` |
| ctl_src | input | 2 | Rate field written by `ctl_wr` |
| flag_clr | input | 1 | Clears the countdown flag |
| out_sel | input | 2 | Interrupt line source select |
| alarm_irq | input | 1 | Alarm request from a neighbour |
| freq_irq | input | 1 | Frequency request from a neighbour |
| irq_out | output | 1 | Shared interrupt line |
| cd_flag | output | 1 | Sticky countdown flag |
| cd_count | output | 8 | Current counter value |

## Verification
The result of a count write, a control write or a selected tick appears on `cd_count` and `cd_flag` in the cycle after the clock edge that samples it. `irq_out` changes in the same cycle as `out_sel` or as its chosen source. The bench drives each input 1 ns after a rising edge and compares every output 1 ns after the next edge. Its model advances one step per edge, so each result is checked in exactly the cycle it is due. The derived rates are checked by counting strobes up to the edge where the flag must rise, with a check one strobe earlier to confirm the flag is still low there.

// File: rtl/cd_timer_pkg.sv
// Package: shared encodings for the countdown timer.
// Assumes: the two-bit rate and output-select fields decode as listed here.
package cd_timer_pkg;

    // Tick rate that steps the counter
    typedef enum logic [1:0] {
        SRC_BASE = 2'b00,
        SRC_FAST = 2'b01,
        SRC_SEC  = 2'b10,
        SRC_MIN  = 2'b11
    } cd_src_t;

    // Source shown on the shared interrupt line
    typedef enum logic [1:0] {
        IRQ_NONE  = 2'b00,
        IRQ_ALARM = 2'b01,
        IRQ_FREQ  = 2'b10,
        IRQ_CDOWN = 2'b11
    } cd_irq_sel_t;

endpackage

// File: rtl/cd_rate_div.sv
// Module: cd_rate_div
// Divides a strobe stream by DIV. It emits one strobe for every DIV input
// strobes, coinciding with the DIV-th one.
// Assumes: in_tick lasts one cycle; restart returns the phase to zero and
// suppresses the output in that cycle.
module cd_rate_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    input  logic restart,
    output logic out_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;
    logic          at_last;

    assign at_last = (phase_q == LAST);

    // Phase counter: advances on each input strobe, wraps at DIV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (in_tick) begin
            phase_q <= at_last ? '0 : phase_q + 1'b1;
        end
    end

    // Output strobe on the wrapping input strobe
    always_comb begin
        out_tick = in_tick && at_last && !restart;
    end
endmodule

// File: rtl/cd_tick_gen.sv
// Module: cd_tick_gen
// Derives the four step rates and picks the one named by src.
// Assumes: base_tick and sec_tick are one-cycle strobes from the timekeeping
// core; restart holds both dividers at their start phase.
module cd_tick_gen
    import cd_timer_pkg::*;
#(
    parameter int FAST_DIV = 64,
    parameter int MIN_DIV  = 60
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    base_tick,
    input  logic    sec_tick,
    input  logic    restart,
    input  cd_src_t src,
    output logic    src_tick
);
    localparam int NDIV = 2;

    logic [NDIV-1:0] div_in;
    logic [NDIV-1:0] div_out;
    logic            tick_fast;
    logic            tick_min;

    assign div_in = {sec_tick, base_tick};

    // One divider per derived rate: index 0 from the base strobe, 1 from seconds
    for (genvar g = 0; g < NDIV; g++) begin : g_div
        localparam int RATIO = (g == 0) ? FAST_DIV : MIN_DIV;
        cd_rate_div #(.DIV(RATIO)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_tick  (div_in[g]),
            .restart  (restart),
            .out_tick (div_out[g])
        );
    end

    assign tick_fast = div_out[0];
    assign tick_min  = div_out[1];

    // Rate select
    always_comb begin
        unique case (src)
            SRC_BASE: src_tick = base_tick;
            SRC_FAST: src_tick = tick_fast;
            SRC_SEC:  src_tick = sec_tick;
            SRC_MIN:  src_tick = tick_min;
            default:  src_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/cd_counter.sv
// Module: cd_counter
// The down-counter with its reload register and sticky flag. A stored 0
// counts as 2**CNT_W ticks, because the counter expires on the tick seen at 1.
// Assumes: a load has priority over a tick, and setting the flag has priority
// over clearing it.
module cd_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload_q;
    logic             expire;

    // Expiry: a selected tick while running, with the count at one
    always_comb begin
        expire = run && step && !load && (count == ONE);
    end

    // Count and reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            reload_q <= '0;
        end else if (load) begin
            count    <= load_val;
            reload_q <= load_val;
        end else if (run && step) begin
            count <= expire ? reload_q : count - 1'b1;
        end
    end

    // Sticky flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cd_irq_mux.sv
// Module: cd_irq_mux
// Chooses which request drives the shared interrupt line.
// Assumes: every request input is already a settled level.
module cd_irq_mux
    import cd_timer_pkg::*;
(
    input  cd_irq_sel_t sel,
    input  logic        alarm_req,
    input  logic        freq_req,
    input  logic        cdown_req,
    output logic        irq
);
    // Line select
    always_comb begin
        unique case (sel)
            IRQ_NONE:  irq = 1'b0;
            IRQ_ALARM: irq = alarm_req;
            IRQ_FREQ:  irq = freq_req;
            IRQ_CDOWN: irq = cdown_req;
            default:   irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/cd_timer.sv
// Module: cd_timer (top)
// Countdown timer with a selectable step rate, a sticky expiry flag and the
// shared interrupt line select.
// Assumes: the write strobes last one cycle; base_tick and sec_tick come from
// the timekeeping core, synchronous to clk.
module cd_timer
    import cd_timer_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 64,
    parameter int MIN_DIV  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             sec_tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ctl_wr,
    input  logic             ctl_run,
    input  logic [1:0]       ctl_src,
    input  logic             flag_clr,
    input  logic [1:0]       out_sel,
    input  logic             alarm_irq,
    input  logic             freq_irq,
    output logic             irq_out,
    output logic             cd_flag,
    output logic [CNT_W-1:0] cd_count
);
    logic    run_q;
    cd_src_t src_q;
    logic    src_tick;
    logic    div_restart;

    // Control register: run bit and rate field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            src_q <= SRC_BASE;
        end else if (ctl_wr) begin
            run_q <= ctl_run;
            src_q <= cd_src_t'(ctl_src);
        end
    end

    // Dividers restart on a count write and stay at the start while stopped
    always_comb begin
        div_restart = cnt_wr || !run_q;
    end

    cd_tick_gen #(
        .FAST_DIV (FAST_DIV),
        .MIN_DIV  (MIN_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .sec_tick  (sec_tick),
        .restart   (div_restart),
        .src       (src_q),
        .src_tick  (src_tick)
    );

    cd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .step     (src_tick),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .flag_clr (flag_clr),
        .count    (cd_count),
        .flag     (cd_flag)
    );

    cd_irq_mux u_irq (
        .sel       (cd_irq_sel_t'(out_sel)),
        .alarm_req (alarm_irq),
        .freq_req  (freq_irq),
        .cdown_req (cd_flag),
        .irq       (irq_out)
    );
endmodule

// File: rtl/cd_timer_chk.sv
// Module: cd_timer_chk
// Temporal checks on the countdown timer, bound into every cd_timer instance.
// Assumes: it sees the run bit and the selected tick inside the top.
module cd_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             step,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             flag_clr,
    input logic [1:0]       out_sel,
    input logic             alarm_irq,
    input logic             freq_irq,
    input logic             irq_out,
    input logic             cd_flag,
    input logic [CNT_W-1:0] cd_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2: a write shows up in the next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cd_count == $past(cnt_wdata)));

    // R3: a tick at one raises the flag
    p_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !cnt_wr && cd_count == ONE) |=> cd_flag);

    // R3: any other tick steps the count down by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !cnt_wr && cd_count != ONE)
            |=> (cd_count == CNT_W'($past(cd_count) - ONE)));

    // R4: the flag holds without a clear
    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flag && !flag_clr) |=> cd_flag);

    // R6: stopped counter holds its value
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cd_count));

    // R6: stopped counter raises no flag
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cd_flag) |=> !cd_flag);

    // R7: line follows the select
    p_irq_cd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b11) |-> (irq_out == cd_flag));
    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b00) |-> !irq_out);
    p_irq_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b01) |-> (irq_out == alarm_irq));
    p_irq_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'b10) |-> (irq_out == freq_irq));
endmodule

bind cd_timer cd_timer_chk #(.CNT_W(CNT_W)) u_cd_timer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .step      (src_tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .flag_clr  (flag_clr),
    .out_sel   (out_sel),
    .alarm_irq (alarm_irq),
    .freq_irq  (freq_irq),
    .irq_out   (irq_out),
    .cd_flag   (cd_flag),
    .cd_count  (cd_count)
);

// File: tb/tb_cd_timer.sv
`timescale 1ns/1ps
// Bench for cd_timer: directed corner cases, then seeded random traffic
// compared each cycle against a step model built from the requirements.
module tb_cd_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0, sec_tick = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       ctl_wr = 1'b0, ctl_run = 1'b0;
    logic [1:0] ctl_src = '0;
    logic       flag_clr = 1'b0;
    logic [1:0] out_sel = '0;
    logic       alarm_irq = 1'b0, freq_irq = 1'b0;
    logic       irq_out, cd_flag;
    logic [7:0] cd_count;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Model state
    int       m_fast = 0, m_min = 0;
    logic [7:0] m_cnt = '0, m_rel = '0;
    bit       m_flag = 0, m_run = 0;
    logic [1:0] m_src = '0;

    always #2 clk = ~clk;

    cd_timer dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_irq(input logic [1:0] s, input bit a, input bit f, input bit c);
        case (s)
            2'b00: return 1'b0;
            2'b01: return a;
            2'b10: return f;
            default: return c;
        endcase
    endfunction

    // One clock edge: predict, advance, compare, drop the write strobes
    task automatic cyc(input string tag);
        bit rst_div, ft, mt, st, ex;
        int nf, nm;
        rst_div = cnt_wr || !m_run;
        ft = base_tick && (m_fast == 63) && !rst_div;
        mt = sec_tick && (m_min == 59) && !rst_div;
        case (m_src)
            2'b00: st = base_tick;
            2'b01: st = ft;
            2'b10: st = sec_tick;
            default: st = mt;
        endcase
        ex = m_run && st && !cnt_wr && (m_cnt == 8'd1);
        nf = rst_div ? 0 : (base_tick ? ((m_fast == 63) ? 0 : m_fast + 1) : m_fast);
        nm = rst_div ? 0 : (sec_tick ? ((m_min == 59) ? 0 : m_min + 1) : m_min);
        @(posedge clk);
        #1;
        m_fast = nf;
        m_min = nm;
        if (cnt_wr) begin
            m_cnt = cnt_wdata;
            m_rel = cnt_wdata;
        end else if (m_run && st) begin
            m_cnt = ex ? m_rel : m_cnt - 8'd1;
        end
        if (ex) m_flag = 1;
        else if (flag_clr) m_flag = 0;
        if (ctl_wr) begin
            m_run = ctl_run;
            m_src = ctl_src;
        end
        chk({tag, " count"}, int'(cd_count), int'(m_cnt));
        chk({tag, " flag"}, int'(cd_flag), int'(m_flag));
        chk({tag, " irq R7"}, int'(irq_out), int'(exp_irq(out_sel, alarm_irq, freq_irq, m_flag)));
        cnt_wr = 0;
        ctl_wr = 0;
        flag_clr = 0;
    endtask

    task automatic cycn(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic setup(input bit run, input logic [1:0] src, input logic [7:0] cnt);
        base_tick = 0;
        sec_tick = 0;
        ctl_wr = 1;
        ctl_run = run;
        ctl_src = src;
        cnt_wr = 1;
        cnt_wdata = cnt;
        flag_clr = 1;
        cyc("R11 setup");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        out_sel = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R10: reset state
        chk("R10 count", int'(cd_count), 0);
        chk("R10 flag", int'(cd_flag), 0);
        cyc("R10");

        // R3/R8: count 3 at base rate
        setup(1, 2'b00, 8'd3);
        chk("R2 load", int'(cd_count), 3);
        base_tick = 1;
        cycn("R3", 2);
        chk("R3 at one", int'(cd_count), 1);
        chk("R3 no flag yet", int'(cd_flag), 0);
        cyc("R3");
        chk("R3 flag", int'(cd_flag), 1);
        chk("R8 reload", int'(cd_count), 3);
        chk("R7 irq flag", int'(irq_out), 1);
        base_tick = 0;
        cyc("R4");
        chk("R4 hold", int'(cd_flag), 1);
        flag_clr = 1;
        cyc("R4");
        chk("R4 clear", int'(cd_flag), 0);
        // R4: set wins over clear
        base_tick = 1;
        cycn("R3", 2);
        flag_clr = 1;
        cyc("R4");
        chk("R4 set wins", int'(cd_flag), 1);

        // R2: write wins over a tick
        cnt_wr = 1;
        cnt_wdata = 8'd9;
        cyc("R2");
        chk("R2 write wins", int'(cd_count), 9);

        // R5: zero means 256 ticks
        setup(1, 2'b00, 8'd0);
        base_tick = 1;
        cycn("R5", 255);
        chk("R5 before end", int'(cd_flag), 0);
        chk("R5 count", int'(cd_count), 1);
        cyc("R5");
        chk("R5 flag", int'(cd_flag), 1);
        chk("R5 reload", int'(cd_count), 0);

        // R1: 64th base strobe
        setup(1, 2'b01, 8'd2);
        base_tick = 1;
        sec_tick = 1;
        cycn("R1", 64);
        chk("R1 fast step", int'(cd_count), 1);
        cycn("R1", 63);
        chk("R1 fast no flag", int'(cd_flag), 0);
        cyc("R1");
        chk("R1 fast flag", int'(cd_flag), 1);

        // R1: seconds rate ignores base strobes
        setup(1, 2'b10, 8'd2);
        base_tick = 1;
        cyc("R1");
        chk("R1 base ignored", int'(cd_count), 2);
        sec_tick = 1;
        cyc("R1");
        chk("R1 sec step", int'(cd_count), 1);

        // R1/R5: per-minute rate
        setup(1, 2'b11, 8'd1);
        sec_tick = 1;
        cycn("R1", 59);
        chk("R1 min no flag", int'(cd_flag), 0);
        cyc("R1");
        chk("R1 min flag", int'(cd_flag), 1);

        // R9: rewrite restarts the divider phase
        setup(1, 2'b01, 8'd1);
        base_tick = 1;
        cycn("R9", 40);
        cnt_wr = 1;
        cnt_wdata = 8'd1;
        cyc("R9");
        cycn("R9", 63);
        chk("R9 phase restarted", int'(cd_flag), 0);
        cyc("R9");
        chk("R9 flag", int'(cd_flag), 1);

        // R6: stopped timer holds
        setup(1, 2'b00, 8'd5);
        base_tick = 1;
        cycn("R6", 2);
        ctl_wr = 1;
        ctl_run = 0;
        ctl_src = 2'b00;
        base_tick = 0;
        cyc("R6");
        base_tick = 1;
        cycn("R6", 50);
        chk("R6 hold", int'(cd_count), 3);
        chk("R6 no flag", int'(cd_flag), 0);

        // R7: line select
        base_tick = 0;
        alarm_irq = 1;
        freq_irq = 0;
        out_sel = 2'b01;
        cyc("R7");
        chk("R7 alarm", int'(irq_out), 1);
        out_sel = 2'b10;
        cyc("R7");
        chk("R7 freq", int'(irq_out), 0);
        out_sel = 2'b00;
        cyc("R7");
        chk("R7 off", int'(irq_out), 0);

        // Random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            base_tick = ($urandom % 2) == 0;
            sec_tick = ($urandom % 3) == 0;
            out_sel = 2'($urandom);
            alarm_irq = 1'($urandom);
            freq_irq = 1'($urandom);
            if (($urandom % 90) == 0) begin
                cnt_wr = 1;
                cnt_wdata = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 6);
            end
            if (($urandom % 200) == 0) begin
                ctl_wr = 1;
                ctl_run = ($urandom % 5) != 0;
                ctl_src = 2'($urandom);
            end
            flag_clr = ($urandom % 25) == 0;
            cyc("R3 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule